// File: doc/BRIEF.md
# Split-Permission Direct-Mapped TLB

This block caches virtual-to-physical page translations for a core's instruction fetches, loads and stores. A requester presents a virtual address with its access kind, the current privilege level, the privilege level used for data accesses (the "effective data privilege") and a flag that turns translation off entirely. When the cached entry for that access kind matches, the physical address is returned in the same cycle. Otherwise the block raises a stall, either builds an identity translation (translation off) or asks an external page walker for the leaf page-table entry, checks the permission the access needs, fills the entry and lets the access retry.

The cache has one entry per index but three separate tag arrays, one per access kind. A refill writes a real tag only into the arrays whose permission was granted, so a page that may be read but not written hits for loads and still misses for stores. Supervisor-level permission bits are moved into the user positions before the check when the access runs with supervisor rights. A flush input invalidates all entries. A failed check produces a one-cycle fault pulse naming the access kind and the faulting address.

Top module: `dm_split_tlb`

## Requirements
- R1: The entry index is the low 4 bits of the virtual page number (address bits 15:12 with 4 KiB pages and 16 entries) and the stored tag is the whole page number, so two pages sharing an index evict each other.
- R2: On a hit, `rsp_hit` is high in the same cycle and `rsp_paddr` is the entry's physical page number (bits 31:12) followed by the virtual address bits 11:0.
- R3: A translated miss raises `stall` and holds `walk_req` high with `walk_vpn` equal to the missing page number until `walk_ack`; after a granted fill the held request hits on retry. Any page number, including all ones, can be cached.
- R4: Separate tag arrays: a fill sets the load, store and fetch tags only where read, write and execute respectively are granted, so a page granted read only still misses and is walked again for a store.
- R5: A one-cycle `flush` invalidates every entry of all three arrays; the next access to a previously hitting page misses.
- R6: Translation is skipped (no walker request, physical page equals virtual page) when `req_bare` is 1, or when `req_priv` is machine (2'b11) and either `req_mpriv` is machine or the access is a fetch. Privilege codes: 2'b00 user, 2'b01 supervisor, 2'b11 machine; kind codes: 2'b00 load, 2'b01 store, 2'b10 fetch.
- R7: The identity entry always grants execute and, except when `req_priv` is machine and `req_mpriv` is not machine, also read and write; so a machine fetch with user data privilege leaves the load tag invalid, while a bare access fills all three tags.
- R8: In supervisor mode, and in machine mode with `req_mpriv` supervisor on a load or store, the supervisor bits of the entry are used in place of the user bits.
- R9: In user mode, and in machine mode with user data privilege, only the user bits are used; supervisor bits alone do not grant access.
- R10: A permission shortfall, or a walker response with `walk_err`, gives a one-cycle `fault_valid` with `fault_cause` 2'b01 fetch, 2'b10 load, 2'b11 store and `fault_vaddr` equal to the request address; `fault_cause` is 2'b00 otherwise and nothing is filled.
- R11: Access requires the valid bit; page-table entry layout: bit 0 valid, bits 1/2/3 user read/write/execute, bits 4/5/6 supervisor read/write/execute, bits 31:12 physical page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Access request present; held stable while `stall` is high |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| req_priv | input | 2 | Current privilege level |
| req_mpriv | input | 2 | Effective data privilege level used in machine mode |
| req_bare | input | 1 | Translation disabled |
| stall | output | 1 | Request pending, hold inputs |
| rsp_hit | output | 1 | Translation returned this cycle |
| rsp_paddr | output | 32 | Physical address |
| fault_valid | output | 1 | One-cycle access fault pulse |
| fault_cause | output | 2 | Fault kind: 01 fetch, 10 load, 11 store |
| fault_vaddr | output | 32 | Faulting virtual address |
| walk_req | output | 1 | Page walk request |
| walk_vpn | output | 20 | Page number to walk |
| walk_ack | input | 1 | Walker response valid |
| walk_err | input | 1 | Walker found no usable mapping |
| walk_pte | input | 32 | Leaf page-table entry from the walker |

## Verification
On every cycle the assertions check that a fault lasts one cycle, that a walker request stays up with a steady page number until acknowledged, that a cycle after a flush never hits and that the tag arrays are all invalid after it, and that an untranslated miss goes straight to the check without a walk. Whether a given privilege combination grants or refuses an access, which tag arrays a fill populates, eviction between pages sharing an index, the physical address composition and the fault cause encoding can only be shown by the bench's scenarios, which compare the outcome of each access against values worked out from the requirements.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   // page-table entry permission bit positions (supervisor = user + 3)
   localparam int PB_V   = 0;
   localparam int PB_UR  = 1;
   localparam int PB_UW  = 2;
   localparam int PB_UX  = 3;
   localparam int PB_SR  = 4;
   localparam int PB_SW  = 5;
   localparam int PB_SX  = 6;
   localparam int PERM_W = 7;
   localparam int SUP_OFS = PB_SR - PB_UR;

   localparam logic [1:0] PRIV_U = 2'b00;
   localparam logic [1:0] PRIV_S = 2'b01;
   localparam logic [1:0] PRIV_M = 2'b11;

   localparam logic [1:0] KIND_LOAD  = 2'b00;
   localparam logic [1:0] KIND_STORE = 2'b01;
   localparam logic [1:0] KIND_FETCH = 2'b10;

   localparam logic [1:0] CAUSE_NONE  = 2'b00;
   localparam logic [1:0] CAUSE_FETCH = 2'b01;
   localparam logic [1:0] CAUSE_LOAD  = 2'b10;
   localparam logic [1:0] CAUSE_STORE = 2'b11;

   typedef enum logic [1:0] {
      ST_LOOK  = 2'b00,
      ST_WALK  = 2'b01,
      ST_CHECK = 2'b10
   } tlb_st_e;

   function automatic logic xlat_off(input logic bare, input logic [1:0] priv,
                                     input logic [1:0] mpriv, input logic fetch);
      return bare || ((priv == PRIV_M) && ((mpriv == PRIV_M) || fetch));
   endfunction

   function automatic int unsigned kind_slot(input logic [1:0] kind);
      if (kind == KIND_FETCH) return 2;
      if (kind == KIND_STORE) return 1;
      return 0;
   endfunction

endpackage

// File: rtl/tlb_ent_array.sv
module tlb_ent_array #(
   parameter int   W         = 21,
   parameter int   DEPTH     = 16,
   parameter bit   FLUSH_EN  = 1'b1,
   parameter bit   RST_ONES  = 1'b1,
   localparam int  IW        = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [W-1:0]  wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [W-1:0]  rd_data
);

   localparam logic [W-1:0] RST_VAL = RST_ONES ? {W{1'b1}} : {W{1'b0}};

   logic [W-1:0] mem_q [DEPTH];

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_bad
      $error("tlb_ent_array: DEPTH must be a power of two of at least 2");
   end
   if (W < 1) begin : g_width_bad
      $error("tlb_ent_array: W must be positive");
   end

   if (FLUSH_EN) begin : g_flushable
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
         end else if (flush) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= {W{1'b1}};
         end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
         end
      end

      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_fchk
         // R5
         flush_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flush |=> (mem_q[gi] == {W{1'b1}}))
            else $error("entry %0d still set after flush", gi);
      end
   end else begin : g_plain
      logic unused_flush;
      assign unused_flush = flush;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
         end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
         end
      end
   end

   assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/tlb_perm_unit.sv
module tlb_perm_unit
   import tlb_pkg::*;
#(
   parameter int VPN_W = 20,
   parameter int PPN_W = 20
) (
   input  logic [VPN_W-1:0]  vpn,
   input  logic [1:0]        kind,
   input  logic [1:0]        priv,
   input  logic [1:0]        mpriv,
   input  logic              bare,
   input  logic [PERM_W-1:0] pte_perm,
   input  logic [PPN_W-1:0]  pte_ppn,
   output logic [PPN_W-1:0]  eff_ppn,
   output logic              can_r,
   output logic              can_w,
   output logic              can_x,
   output logic              grant
);

   logic              is_fetch, is_store, byp, rw_ok, use_sup, need;
   logic [PERM_W-1:0] synth_perm, raw_perm;

   assign is_fetch = (kind == KIND_FETCH);
   assign is_store = (kind == KIND_STORE);
   assign byp      = xlat_off(bare, priv, mpriv, is_fetch);

   // identity entry: execute always, read/write unless machine with lowered data privilege
   assign rw_ok = bare || !((priv == PRIV_M) && (mpriv != PRIV_M));

   always_comb begin
      synth_perm         = '0;
      synth_perm[PB_V]   = 1'b1;
      synth_perm[PB_UX]  = 1'b1;
      synth_perm[PB_SX]  = 1'b1;
      synth_perm[PB_UR]  = rw_ok;
      synth_perm[PB_SR]  = rw_ok;
      synth_perm[PB_UW]  = rw_ok;
      synth_perm[PB_SW]  = rw_ok;
   end

   assign raw_perm = byp ? synth_perm : pte_perm;

   if (PPN_W >= VPN_W) begin : g_ppn_wide
      assign eff_ppn = byp ? {{(PPN_W - VPN_W){1'b0}}, vpn} : pte_ppn;
   end else begin : g_ppn_narrow
      logic [VPN_W-PPN_W-1:0] unused_vpn_hi;
      assign unused_vpn_hi = vpn[VPN_W-1:PPN_W];
      assign eff_ppn = byp ? vpn[PPN_W-1:0] : pte_ppn;
   end

   assign use_sup = (priv == PRIV_S) || ((priv == PRIV_M) && (mpriv == PRIV_S) && !is_fetch);

   assign can_r = use_sup ? raw_perm[PB_UR + SUP_OFS] : raw_perm[PB_UR];
   assign can_w = use_sup ? raw_perm[PB_UW + SUP_OFS] : raw_perm[PB_UW];
   assign can_x = use_sup ? raw_perm[PB_UX + SUP_OFS] : raw_perm[PB_UX];

   assign need  = is_fetch ? can_x : (is_store ? can_w : can_r);
   assign grant = raw_perm[PB_V] && need;

endmodule

// File: rtl/tlb_miss_ctl.sv
module tlb_miss_ctl
   import tlb_pkg::*;
#(
   parameter int VPN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             hit,
   input  logic             live_byp,
   input  logic             walk_ack,
   input  logic [VPN_W-1:0] walk_vpn,
   output tlb_st_e          st,
   output logic             latch_en,
   output logic             cap_pte,
   output logic             walk_req
);

   tlb_st_e st_q, st_d;

   assign latch_en = (st_q == ST_LOOK) && req_valid && !hit;
   assign cap_pte  = (st_q == ST_WALK) && walk_ack;
   assign walk_req = (st_q == ST_WALK);
   assign st       = st_q;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_LOOK:  if (latch_en) st_d = live_byp ? ST_CHECK : ST_WALK;
         ST_WALK:  if (walk_ack) st_d = ST_CHECK;
         ST_CHECK: st_d = ST_LOOK;
         default:  st_d = ST_LOOK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_LOOK;
      else        st_q <= st_d;
   end

   // R3
   walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vpn)))
      else $error("walk request dropped before acknowledge");

   // R6
   byp_skip_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en && live_byp) |=> (st_q == ST_CHECK))
      else $error("untranslated miss went to the walker");

endmodule

// File: rtl/dm_split_tlb.sv
module dm_split_tlb
   import tlb_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int ENTRIES   = 16,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PPN_W    = PA_W - PAGE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [1:0]       req_kind,
   input  logic [1:0]       req_priv,
   input  logic [1:0]       req_mpriv,
   input  logic             req_bare,
   output logic             stall,
   output logic             rsp_hit,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             fault_valid,
   output logic [1:0]       fault_cause,
   output logic [VA_W-1:0]  fault_vaddr,
   output logic             walk_req,
   output logic [VPN_W-1:0] walk_vpn,
   input  logic             walk_ack,
   input  logic             walk_err,
   input  logic [PA_W-1:0]  walk_pte
);

   localparam int IDX_W  = $clog2(ENTRIES);
   localparam int TAG_W  = VPN_W + 1;   // extra top bit keeps real tags off the all-ones marker
   localparam int N_KIND = 3;

   if (PAGE_BITS < PERM_W) begin : g_page_bad
      $error("dm_split_tlb: PAGE_BITS must hold the permission bits");
   end
   if (VPN_W < IDX_W) begin : g_vpn_bad
      $error("dm_split_tlb: page number narrower than index");
   end
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_ent_bad
      $error("dm_split_tlb: ENTRIES must be a power of two");
   end

   tlb_st_e st;
   logic    latch_en, cap_pte;

   // live lookup
   logic [VPN_W-1:0] live_vpn;
   logic [IDX_W-1:0] live_idx;
   logic             live_byp;
   logic [TAG_W-1:0] tag_rd [N_KIND];
   logic [PPN_W-1:0] ppn_rd;
   logic [TAG_W-1:0] sel_tag;

   assign live_vpn = req_vaddr[VA_W-1:PAGE_BITS];
   assign live_idx = live_vpn[IDX_W-1:0];
   assign live_byp = xlat_off(req_bare, req_priv, req_mpriv, req_kind == KIND_FETCH);
   assign sel_tag  = tag_rd[kind_slot(req_kind)];

   assign rsp_hit   = req_valid && (st == ST_LOOK) && (sel_tag == {1'b0, live_vpn});
   assign rsp_paddr = {ppn_rd, req_vaddr[PAGE_BITS-1:0]};

   // captured request
   logic [VA_W-1:0]   q_vaddr;
   logic [1:0]        q_kind, q_priv, q_mpriv;
   logic              q_bare;
   logic [PERM_W-1:0] q_perm;
   logic [PPN_W-1:0]  q_ppn;
   logic [VPN_W-1:0]  q_vpn;
   logic [IDX_W-1:0]  q_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_vaddr <= '0;
         q_kind  <= KIND_LOAD;
         q_priv  <= PRIV_M;
         q_mpriv <= PRIV_M;
         q_bare  <= 1'b1;
      end else if (latch_en) begin
         q_vaddr <= req_vaddr;
         q_kind  <= req_kind;
         q_priv  <= req_priv;
         q_mpriv <= req_mpriv;
         q_bare  <= req_bare;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_perm <= '0;
         q_ppn  <= '0;
      end else if (cap_pte) begin
         q_perm <= walk_err ? '0 : walk_pte[PERM_W-1:0];
         q_ppn  <= walk_err ? '0 : walk_pte[PA_W-1:PAGE_BITS];
      end
   end

   logic [PAGE_BITS-PERM_W-1:0] unused_pte_mid;
   assign unused_pte_mid = walk_pte[PAGE_BITS-1:PERM_W];

   assign q_vpn    = q_vaddr[VA_W-1:PAGE_BITS];
   assign q_idx    = q_vpn[IDX_W-1:0];
   assign walk_vpn = q_vpn;

   tlb_miss_ctl #(.VPN_W(VPN_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .hit       (rsp_hit),
      .live_byp  (live_byp),
      .walk_ack  (walk_ack),
      .walk_vpn  (walk_vpn),
      .st        (st),
      .latch_en  (latch_en),
      .cap_pte   (cap_pte),
      .walk_req  (walk_req)
   );

   // permission check on the captured request
   logic [PPN_W-1:0] eff_ppn;
   logic             can_r, can_w, can_x, grant;
   logic [N_KIND-1:0] kind_ok;

   tlb_perm_unit #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_perm (
      .vpn      (q_vpn),
      .kind     (q_kind),
      .priv     (q_priv),
      .mpriv    (q_mpriv),
      .bare     (q_bare),
      .pte_perm (q_perm),
      .pte_ppn  (q_ppn),
      .eff_ppn  (eff_ppn),
      .can_r    (can_r),
      .can_w    (can_w),
      .can_x    (can_x),
      .grant    (grant)
   );

   assign kind_ok = {can_x, can_w, can_r};

   logic fill_en;
   assign fill_en     = (st == ST_CHECK) && grant;
   assign fault_valid = (st == ST_CHECK) && !grant;
   assign fault_vaddr = q_vaddr;

   always_comb begin
      fault_cause = CAUSE_NONE;
      if (fault_valid) begin
         case (q_kind)
            KIND_FETCH: fault_cause = CAUSE_FETCH;
            KIND_STORE: fault_cause = CAUSE_STORE;
            default:    fault_cause = CAUSE_LOAD;
         endcase
      end
   end

   assign stall = req_valid && !rsp_hit && !fault_valid;

   // one tag array per access kind: slot 0 load, 1 store, 2 fetch
   for (genvar gk = 0; gk < N_KIND; gk++) begin : g_tags
      tlb_ent_array #(.W(TAG_W), .DEPTH(ENTRIES), .FLUSH_EN(1'b1), .RST_ONES(1'b1)) u_tag (
         .clk     (clk),
         .rst_n   (rst_n),
         .flush   (flush),
         .wr_en   (fill_en),
         .wr_idx  (q_idx),
         .wr_data (kind_ok[gk] ? {1'b0, q_vpn} : {TAG_W{1'b1}}),
         .rd_idx  (live_idx),
         .rd_data (tag_rd[gk])
      );
   end

   tlb_ent_array #(.W(PPN_W), .DEPTH(ENTRIES), .FLUSH_EN(1'b0), .RST_ONES(1'b0)) u_ppn (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (fill_en),
      .wr_idx  (q_idx),
      .wr_data (eff_ppn),
      .rd_idx  (live_idx),
      .rd_data (ppn_rd)
   );

   // R10
   fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |=> !fault_valid)
      else $error("fault held longer than one cycle");

   // R10
   hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && fault_valid))
      else $error("hit and fault in the same cycle");

   // R5
   flush_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !rsp_hit)
      else $error("hit right after flush");

endmodule

// File: tb/tb_dm_split_tlb.sv
module tb_dm_split_tlb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0, req_priv = '0, req_mpriv = '0;
   logic        req_bare = 1'b0;
   logic        stall, rsp_hit, fault_valid, walk_req;
   logic [31:0] rsp_paddr, fault_vaddr;
   logic [1:0]  fault_cause;
   logic [19:0] walk_vpn;
   logic        walk_ack = 1'b0, walk_err = 1'b0;
   logic [31:0] walk_pte = '0;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dm_split_tlb dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
      .req_vaddr(req_vaddr), .req_kind(req_kind), .req_priv(req_priv),
      .req_mpriv(req_mpriv), .req_bare(req_bare), .stall(stall),
      .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .fault_valid(fault_valid),
      .fault_cause(fault_cause), .fault_vaddr(fault_vaddr), .walk_req(walk_req),
      .walk_vpn(walk_vpn), .walk_ack(walk_ack), .walk_err(walk_err), .walk_pte(walk_pte)
   );

   typedef struct packed {
      logic        fl;      // pulse flush before this access
      logic [31:0] va;
      logic [1:0]  kind;
      logic [1:0]  priv;
      logic [1:0]  mpriv;
      logic        bare;
      logic [31:0] pte;
      logic        werr;
      logic        ewalk;
      logic        efault;
      logic [1:0]  ecause;
      logic [31:0] epa;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 21;
   // kind 0 load 1 store 2 fetch; priv 0 U 1 S 3 M; cause 1 fetch 2 load 3 store
   localparam vec_t VECS [NV] = '{
      '{1'b0, 32'h0001_2345, 2'd0, 2'd0, 2'd0, 1'b0, 32'h0ABC_D003, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0ABC_D345, 8'd3},  // R3 miss, walk, retry
      '{1'b0, 32'h0001_2FF0, 2'd0, 2'd0, 2'd0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 2'd0, 32'h0ABC_DFF0, 8'd2},  // R2 hit, offset
      '{1'b0, 32'h0001_2010, 2'd1, 2'd0, 2'd0, 1'b0, 32'h0ABC_D003, 1'b0, 1'b1, 1'b1, 2'd3, 32'h0,         8'd4},  // R4 read-only page, store walks and faults
      '{1'b0, 32'h0002_2000, 2'd0, 2'd0, 2'd0, 1'b0, 32'h0555_5003, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0555_5000, 8'd1},  // R1 same index
      '{1'b0, 32'h0001_2008, 2'd0, 2'd0, 2'd0, 1'b0, 32'h0ABC_D003, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0ABC_D008, 8'd1},  // R1 evicted
      '{1'b0, 32'h0003_3004, 2'd0, 2'd1, 2'd0, 1'b0, 32'h0777_7011, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0777_7004, 8'd8},  // R8 S uses SR
      '{1'b0, 32'h0004_4000, 2'd0, 2'd1, 2'd0, 1'b0, 32'h0777_7003, 1'b0, 1'b1, 1'b1, 2'd2, 32'h0,         8'd8},  // R8 S ignores UR
      '{1'b0, 32'h0005_5000, 2'd0, 2'd0, 2'd0, 1'b0, 32'h0111_1011, 1'b0, 1'b1, 1'b1, 2'd2, 32'h0,         8'd9},  // R9 U ignores SR
      '{1'b0, 32'h0006_6000, 2'd2, 2'd0, 2'd0, 1'b0, 32'h0111_100E, 1'b0, 1'b1, 1'b1, 2'd1, 32'h0,         8'd11}, // R11 no valid bit
      '{1'b0, 32'h0007_7000, 2'd0, 2'd0, 2'd0, 1'b0, 32'h0999_900F, 1'b1, 1'b1, 1'b1, 2'd2, 32'h0,         8'd10}, // R10 walker error
      '{1'b0, 32'h0008_8123, 2'd0, 2'd0, 2'd0, 1'b1, 32'h0,         1'b0, 1'b0, 1'b0, 2'd0, 32'h0008_8123, 8'd6},  // R6 bare
      '{1'b0, 32'h0008_8456, 2'd1, 2'd0, 2'd0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 2'd0, 32'h0008_8456, 8'd7},  // R7 bare filled store tag
      '{1'b0, 32'h0009_9ABC, 2'd1, 2'd3, 2'd3, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 2'd0, 32'h0009_9ABC, 8'd6},  // R6 M with mpriv M
      '{1'b0, 32'h000A_A010, 2'd2, 2'd3, 2'd0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 2'd0, 32'h000A_A010, 8'd6},  // R6 M fetch
      '{1'b0, 32'h000A_A020, 2'd0, 2'd0, 2'd0, 1'b0, 32'h0222_2003, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0222_2020, 8'd7},  // R7 fetch-only identity
      '{1'b0, 32'h000B_B040, 2'd0, 2'd3, 2'd1, 1'b0, 32'h0333_3011, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0333_3040, 8'd8},  // R8 M mpriv S load
      '{1'b0, 32'h000C_C000, 2'd1, 2'd3, 2'd1, 1'b0, 32'h0333_3007, 1'b0, 1'b1, 1'b1, 2'd3, 32'h0,         8'd8},  // R8 M mpriv S store
      '{1'b0, 32'h000D_D000, 2'd0, 2'd3, 2'd0, 1'b0, 32'h0444_4003, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0444_4000, 8'd9},  // R9 M mpriv U translated
      '{1'b0, 32'hFFFF_F010, 2'd2, 2'd0, 2'd0, 1'b0, 32'h0666_6009, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0666_6010, 8'd3},  // R3 all-ones page
      '{1'b0, 32'h0008_8000, 2'd0, 2'd0, 2'd0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 2'd0, 32'h0008_8000, 8'd5},  // R5 before flush
      '{1'b1, 32'h0008_8000, 2'd0, 2'd0, 2'd0, 1'b0, 32'h0888_8003, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0888_8000, 8'd5}   // R5 after flush
   };

   task automatic check(input bit ok, input int rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      bit saw_walk = 1'b0;
      bit acked = 1'b0;
      bit done = 1'b0;
      bit got_fault = 1'b0;
      logic [1:0]  cause = '0;
      logic [31:0] fva = '0, pa = '0;
      int cyc = 0;
      if (v.fl) begin
         @(negedge clk); flush = 1'b1;
         @(negedge clk); flush = 1'b0;
      end
      @(negedge clk);
      req_vaddr = v.va; req_kind = v.kind; req_priv = v.priv;
      req_mpriv = v.mpriv; req_bare = v.bare; req_valid = 1'b1;
      while (!done && cyc < 60) begin
         #1;
         if (cyc == 0 && v.ewalk)
            check(stall == 1'b1, 3, "stall on miss", {31'b0, stall}, 32'd1);
         if (walk_req && !acked) begin
            saw_walk = 1'b1;
            acked = 1'b1;
            check(walk_vpn == v.va[31:12], 3, "walk page number", {12'b0, walk_vpn}, {12'b0, v.va[31:12]});
            walk_ack = 1'b1; walk_pte = v.pte; walk_err = v.werr;
         end
         if (rsp_hit) begin done = 1'b1; pa = rsp_paddr; end
         if (fault_valid) begin done = 1'b1; got_fault = 1'b1; cause = fault_cause; fva = fault_vaddr; end
         if (!done) begin
            @(negedge clk);
            walk_ack = 1'b0; walk_err = 1'b0;
            cyc++;
         end
      end
      check(saw_walk == v.ewalk, v.rq, "walker used", {31'b0, saw_walk}, {31'b0, v.ewalk});
      check(got_fault == v.efault, v.rq, "fault raised", {31'b0, got_fault}, {31'b0, v.efault});
      if (v.efault) begin
         check(cause == v.ecause, v.rq, "fault cause", {30'b0, cause}, {30'b0, v.ecause});
         check(fva == v.va, 10, "fault address", fva, v.va);
      end else begin
         check(pa == v.epa, v.rq, "physical address", pa, v.epa);
      end
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      if (got_fault)
         check(fault_valid == 1'b0 && fault_cause == 2'b00, 10, "fault one cycle",
               {31'b0, fault_valid}, 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // reset state (R10, R3)
      check(!stall && !rsp_hit && !walk_req, 3, "idle after reset",
            {29'b0, stall, rsp_hit, walk_req}, 32'd0);
      check(!fault_valid && fault_cause == 2'b00, 10, "no fault after reset",
            {29'b0, fault_valid, fault_cause}, 32'd0);
      for (int i = 0; i < NV; i++) run_vec(VECS[i]);
      // flush while idle then re-touch a translated page (R5)
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      run_vec('{1'b0, 32'h0001_2008, 2'd0, 2'd0, 2'd0, 1'b0, 32'h0ABC_D003, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0ABC_D008, 8'd5});
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule